// File: doc/BRIEF.md
# Test-Under-Mask Condition Unit

This unit produces the 2-bit condition code for two related mask operations. In a test operation, a mask selects bits of a value and the code reports whether the selected bits are all zero, all one, or mixed. In an insert operation, the code reports whether the selected field is zero and, if not, the state of its leftmost bit. The unit does not move any bytes and holds no architectural state. It only computes the code, for an execute stage that forwards the code to its flag logic.

A leading-zero counter finds the leftmost set bit of the mask. In a mixed 64-bit test and in an insert, the value is shifted left by that count, and the bit that reaches the top decides the code. The path is combinational. A parameter adds an output register stage that loads only while an enable input is high.

Mode encoding on `mode`: `2'b00` narrow test (low half of the word), `2'b01` full-width test, `2'b10` insert, `2'b11` reserved.

Top module: `tmcc_unit`

## Requirements
- R1: In any of the three active modes, when value AND mask (restricted to the low half in narrow test, mode 00) is zero but the mask is not, the code is 0.
- R2: In full-width test (mode 01), when value AND mask equals a nonzero mask, the code is 3. The same holds in narrow test for the low halves.
- R3: In full-width test (mode 01) with a mixed result, the code is 2 when the value bit at the position of the mask's most significant set bit is 1, and 1 when that bit is 0.
- R4: Narrow test (mode 00) looks only at the low DATA_W/2 bits of value and mask, and the upper bits have no effect. A mixed result there always gives code 1.
- R5: In insert mode (mode 10) with a nonzero selected field, the code is 1 when the value bit under the leftmost set mask bit is 1, and 2 when it is 0. The code is never 3 in this mode.
- R6: The reserved mode 11 always gives code 0.
- R7: With OUT_REG=1, the code appears on `cc` one clock edge after the inputs are presented with `en` high. While `en` is low, `cc` holds its value.
- R8: While `rst_n` is low, `cc` is 0.
- R9: An all-zero mask (in the half that the mode uses) gives code 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load enable of the output register |
| mode | input | 2 | Operation select: 00 narrow test, 01 full test, 10 insert, 11 reserved |
| value | input | DATA_W | Operand whose bits are examined |
| mask | input | DATA_W | Bit selection mask |
| cc | output | 2 | Condition code |

## Verification
A wrong leading-zero count would not show in an all-zero or all-one result. It shows only in the mixed full-width test and in insert mode, where the wrong value bit decides between codes 1 and 2, one cycle after the inputs are presented. The sweeps therefore move a small exhaustive nibble pattern across the low edge, the half boundary and the top of the word. This sets up mixed fields whose leftmost mask bit is at a known position. Narrow-mode checks load the upper halves with random data, so any leak of those bits changes the code on the next cycle. Checks with the enable low and checks during reset show a register that loads without `en` or ignores `rst_n`.

// File: rtl/tmcc_pkg.sv
package tmcc_pkg;

  typedef enum logic [1:0] {
    TMC_NARROW = 2'b00,
    TMC_WIDE   = 2'b01,
    TMC_INSERT = 2'b10,
    TMC_RSVD   = 2'b11
  } tmc_mode_e;

  typedef logic [1:0] tmc_code_t;

  localparam tmc_code_t CODE_ZERO  = 2'd0;
  localparam tmc_code_t CODE_ONE   = 2'd1;
  localparam tmc_code_t CODE_TWO   = 2'd2;
  localparam tmc_code_t CODE_THREE = 2'd3;

endpackage

// File: rtl/tmcc_lzc.sv
// Leading-zero counter: priority encoder, returns W for an all-zero vector.
module tmcc_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);

  always_comb begin
    cnt = CW'(W);
    // ascending scan: the highest set bit is written last and wins
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/tmcc_eval.sv
// Combinational code selection for the three operation modes.
module tmcc_eval
  import tmcc_pkg::*;
#(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [1:0]    mode,
  input  logic [W-1:0]  value,
  input  logic [W-1:0]  mask,
  input  logic [CW-1:0] lz,
  output tmc_code_t     code
);

  localparam int HW = W / 2;

  logic [W-1:0]  sel_wide;
  logic [HW-1:0] sel_narrow;
  logic [W-1:0]  aligned;
  logic          lead_bit;
  tmc_mode_e     op;

  always_comb begin
    op         = tmc_mode_e'(mode);
    sel_wide   = value & mask;
    sel_narrow = value[HW-1:0] & mask[HW-1:0];
    aligned    = value << lz;
    lead_bit   = aligned[W-1];
    code       = CODE_ZERO;
    unique case (op)
      TMC_NARROW: begin
        if (sel_narrow == '0)                 code = CODE_ZERO;
        else if (sel_narrow == mask[HW-1:0])  code = CODE_THREE;
        else                                  code = CODE_ONE;
      end
      TMC_WIDE: begin
        if (sel_wide == '0)                   code = CODE_ZERO;
        else if (sel_wide == mask)            code = CODE_THREE;
        else if (lead_bit)                    code = CODE_TWO;
        else                                  code = CODE_ONE;
      end
      TMC_INSERT: begin
        if (sel_wide == '0)                   code = CODE_ZERO;
        else if (lead_bit)                    code = CODE_ONE;
        else                                  code = CODE_TWO;
      end
      default:                                code = CODE_ZERO;
    endcase
  end

endmodule

// File: rtl/tmcc_unit.sv
module tmcc_unit
  import tmcc_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] mask,
  output logic [1:0]        cc
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] lead_zeros;
  tmc_code_t        cc_d;

  tmcc_lzc #(.W(DATA_W), .CW(CNT_W)) u_lzc (
    .vec (mask),
    .cnt (lead_zeros)
  );

  tmcc_eval #(.W(DATA_W), .CW(CNT_W)) u_eval (
    .mode  (mode),
    .value (value),
    .mask  (mask),
    .lz    (lead_zeros),
    .code  (cc_d)
  );

  generate
    if (OUT_REG) begin : g_reg
      tmc_code_t cc_q;
      tmc_code_t cc_nxt;

      always_comb begin
        cc_nxt = cc_q;
        if (en) cc_nxt = cc_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cc_q <= CODE_ZERO;
        else        cc_q <= cc_nxt;
      end

      assign cc = cc_q;
    end else begin : g_comb
      assign cc = cc_d;
    end
  endgenerate

endmodule

// File: rtl/tmcc_unit_chk.sv
module tmcc_unit_chk #(
  parameter int DATA_W  = 64,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [1:0]        mode,
  input logic [DATA_W-1:0] value,
  input logic [DATA_W-1:0] mask,
  input logic [1:0]        cc
);

  generate
    if (OUT_REG) begin : g_seq
      p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cc));

      p_zero_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
        en && ((value & mask) == '0) |=> cc == 2'd0);

      p_full_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en && (mode == 2'b01) && (mask != '0) && ((value & mask) == mask)
        |=> cc == 2'd3);

      p_narrow_no_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en && (mode == 2'b00) |=> cc != 2'd2);

      p_insert_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en && (mode == 2'b10) && ((value & mask) != '0)
        |=> (cc == 2'd1) || (cc == 2'd2));

      p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en && (mode == 2'b11) |=> cc == 2'd0);
    end else begin : g_comb
      always_comb begin
        if (rst_n && (mode == 2'b11))
          p_reserved_comb_r6: assert (cc == 2'd0);
        if (rst_n && en && ((value & mask) == '0))
          p_zero_comb_r1: assert (cc == 2'd0);
      end
    end
  endgenerate

endmodule

bind tmcc_unit tmcc_unit_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en    (en),
  .mode  (mode),
  .value (value),
  .mask  (mask),
  .cc    (cc)
);

// File: tb/tmcc_unit_test.sv
module tmcc_unit_test;

  localparam int CLK_P = 10;
  localparam int W     = 64;
  localparam int HW    = W / 2;

  logic         clk;
  logic         rst_n;
  logic         en;
  logic [1:0]   mode;
  logic [W-1:0] value;
  logic [W-1:0] mask;
  logic [1:0]   cc;

  int checks;
  int errors;
  bit done;

  tmcc_unit #(.DATA_W(W), .OUT_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
    .value(value), .mask(mask), .cc(cc)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  // reference: scan the mask from the top for its leftmost set bit
  function automatic logic [1:0] ref_code(logic [1:0] md, logic [W-1:0] v, logic [W-1:0] m);
    logic [W-1:0]  f;
    logic [HW-1:0] fn;
    logic          top_v;
    bit            found;
    top_v = 1'b0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && m[i]) begin
        top_v = v[i];
        found = 1'b1;
      end
    end
    f  = v & m;
    fn = v[HW-1:0] & m[HW-1:0];
    case (md)
      2'b00: ref_code = (fn == 0) ? 2'd0 : (fn == m[HW-1:0]) ? 2'd3 : 2'd1;
      2'b01: ref_code = (f == 0) ? 2'd0 : (f == m) ? 2'd3 : (top_v ? 2'd2 : 2'd1);
      2'b10: ref_code = (f == 0) ? 2'd0 : (top_v ? 2'd1 : 2'd2);
      default: ref_code = 2'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] md, logic [W-1:0] v, logic [W-1:0] m);
    logic [W-1:0] mm;
    mm = (md == 2'b00) ? {{HW{1'b0}}, m[HW-1:0]} : m;
    if (md == 2'b11) return "R6";
    if (mm == 0) return "R9";
    if ((v & mm) == 0) return "R1";
    if (md == 2'b00) return "R4";
    if (md == 2'b10) return "R5";
    if ((v & mm) == mm) return "R2";
    return "R3";
  endfunction

  task automatic check(string req, logic [1:0] got, logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: cc=%0d expected %0d (mode=%0d value=%h mask=%h)",
               req, got, exp, mode, value, mask);
    end
  endtask

  // present inputs at a falling edge, compare after the next rising edge
  task automatic run_vec(logic [1:0] md, logic [W-1:0] v, logic [W-1:0] m);
    mode  = md;
    value = v;
    mask  = m;
    en    = 1'b1;
    @(negedge clk);
    check(tag_of(md, v, m), cc, ref_code(md, v, m));
  endtask

  task automatic run_tagged(string req, logic [1:0] md, logic [W-1:0] v, logic [W-1:0] m);
    mode  = md;
    value = v;
    mask  = m;
    en    = 1'b1;
    @(negedge clk);
    check(req, cc, ref_code(md, v, m));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete (expected completion)");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] held;
    int         pos[4];
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b1;
    en     = 1'b0;
    mode   = 2'b00;
    value  = '0;
    mask   = '0;
    #2 rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8", cc, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // nibble sweep across the bottom, the half boundary and the top
    pos[0] = 0; pos[1] = 30; pos[2] = 40; pos[3] = 60;
    for (int p = 0; p < 4; p++)
      for (int md = 0; md < 4; md++)
        for (int mv = 0; mv < 16; mv++)
          for (int vv = 0; vv < 16; vv++)
            run_vec(2'(md), W'(vv) << pos[p], W'(mv) << pos[p]);

    // corner masks
    for (int md = 0; md < 4; md++) begin
      run_vec(2'(md), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
      run_vec(2'(md), 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
      run_vec(2'(md), 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
      run_vec(2'(md), 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF);
      run_vec(2'(md), 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF);
      run_vec(2'(md), 64'h1234_5678_9ABC_DEF0, 64'h0);
      for (int b = 0; b < W; b++) begin
        run_vec(2'(md), W'(1) << b, W'(1) << b);
        run_vec(2'(md), ~(W'(1) << b), W'(1) << b);
      end
    end

    // upper-half garbage must not change narrow results
    for (int k = 0; k < 300; k++)
      run_tagged("R4", 2'b00, {$urandom, $urandom}, {$urandom, $urandom});

    // random mixed vectors
    for (int k = 0; k < 2000; k++)
      run_vec(2'(k % 4), {$urandom, $urandom}, {$urandom, $urandom});

    // enable low: output holds
    run_tagged("R7", 2'b01, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0003);
    held  = cc;
    check("R7", held, 2'd2);
    en    = 1'b0;
    mode  = 2'b10;
    value = 64'h0;
    mask  = 64'hFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7", cc, held);
    end

    // reset mid-run clears a nonzero code
    run_tagged("R2", 2'b01, 64'hF0, 64'hF0);
    rst_n = 1'b0;
    #1;
    check("R8", cc, 2'd0);
    @(negedge clk);
    check("R8", cc, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule